// File: doc/BRIEF.md
# Edge-Detecting General-Purpose Pin Bank

This block manages a bank of general-purpose pins through a small memory-mapped register port. Each pin can be an input or an output. Software changes output levels only through two strobe registers, one that raises the selected outputs and one that lowers them, so concurrent updates to different pins never need a read-modify-write. A level register reads back the synchronised state seen at every pin, whatever its direction.

Every input passes through a multi-flop synchroniser. Per-pin rising and falling enables select which transitions latch into a sticky event register. Software clears that register by writing ones. The bank raises a single interrupt request whenever any event bit is pending. A build-time mask can reverse the direction sense of selected pins so that a stored 0 makes them outputs.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset the direction, output and both enable registers read 0, the event register reads 0, the interrupt is low, every output drives 0, and the output-enable vector equals the inversion mask.
- R2: A write to offset 0x18 drives high every output whose data bit is 1 and leaves the others unchanged. Reading 0x18 returns the output latch.
- R3: A write to offset 0x24 drives low every output whose data bit is 1 and leaves the others unchanged. Reading 0x24 returns the output latch.
- R4: The direction register at offset 0x0C reads back as written. A pin's output enable is its direction bit, reversed for pins whose bit is set in the inversion mask.
- R5: Offset 0x00 returns the pin inputs after a two-flop synchroniser, for input and output pins alike. A read issued in the same cycle as a pin change still returns the old level.
- R6: A 0-to-1 transition on a pin whose rising enable (offset 0x30) is 1 sets that pin's bit in the event register at offset 0x48. Without the enable, no bit is set.
- R7: A 1-to-0 transition on a pin whose falling enable (offset 0x3C) is 1 sets that pin's event bit. Without the enable, no bit is set.
- R8: Writing 1 to an event bit clears it. Writing 0 leaves it unchanged. Writing all ones clears every pending event.
- R9: Clearing a pin's enables stops new events on that pin and leaves a bit that is already pending set.
- R10: When a new enabled edge and a clearing write reach the same event bit in the same cycle, the bit stays set.
- R11: The interrupt request is high exactly when at least one event bit is set.
- R12: Read data is registered and appears one cycle after the read strobe. Offsets outside the map read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after a read |
| pin_in | input | 32 | Raw pad inputs |
| pin_out | output | 32 | Output levels |
| pin_oe | output | 32 | Output enables, 1 = drive |
| irq | output | 1 | Bank interrupt request |

## Verification
The output strobes are exercised with words that mix ones and zeros, so a wrong polarity or a whole-word overwrite changes the untouched bits. Edge events are driven on several pins at once, with only some of the enables set, which separates rising from falling detection and shows that disabled pins stay quiet. Partial, zero and all-ones clearing writes distinguish a per-bit clear from a register overwrite. A clear timed to land in the same cycle as a new edge tells "edge wins" apart from "clear wins". A read issued in the same cycle as a pin change checks the synchroniser depth.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

   typedef enum logic [7:0] {
      OFS_LEVEL = 8'h00,
      OFS_DIR   = 8'h0C,
      OFS_SET   = 8'h18,
      OFS_CLR   = 8'h24,
      OFS_RISE  = 8'h30,
      OFS_FALL  = 8'h3C,
      OFS_EVT   = 8'h48
   } reg_ofs_e;

   typedef struct packed {
      logic dir;
      logic set;
      logic clr;
      logic rise;
      logic fall;
      logic evt;
   } wr_strobe_t;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] raw_in,
   output logic [WIDTH-1:0] sync_out
);

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= raw_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_edge_unit.sv
module gpio_edge_unit #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level,
   input  logic [WIDTH-1:0] rise_en,
   input  logic [WIDTH-1:0] fall_en,
   input  logic             clr_wr,
   input  logic [WIDTH-1:0] clr_mask,
   output logic [WIDTH-1:0] evt_q,
   output logic             any_evt
);

   logic [WIDTH-1:0] prev_q;
   logic [WIDTH-1:0] hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= level;
   end

   assign hit = (level & ~prev_q & rise_en) | (~level & prev_q & fall_en);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      evt_q[i] <= 1'b0;
         else if (hit[i])                 evt_q[i] <= 1'b1;
         else if (clr_wr && clr_mask[i])  evt_q[i] <= 1'b0;
      end
   end

   assign any_evt = |evt_q;

endmodule

// File: rtl/gpio_out_ctrl.sv
module gpio_out_ctrl #(
   parameter int unsigned     WIDTH    = 32,
   parameter logic [WIDTH-1:0] INV_MASK = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_wr,
   input  logic             clr_wr,
   input  logic [WIDTH-1:0] mask,
   input  logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] out_q,
   output logic [WIDTH-1:0] oe
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      out_q <= '0;
      else if (set_wr) out_q <= out_q | mask;
      else if (clr_wr) out_q <= out_q & ~mask;
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_dir
      if (INV_MASK[i]) begin : g_inv
         assign oe[i] = ~dir_q[i];
      end else begin : g_norm
         assign oe[i] = dir_q[i];
      end
   end

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
   import gpio_edge_pkg::*;
#(
   parameter int unsigned      PIN_W       = 32,
   parameter int unsigned      DATA_W      = 32,
   parameter int unsigned      ADDR_W      = 8,
   parameter int unsigned      SYNC_STAGES = 2,
   parameter logic [PIN_W-1:0] INV_MASK    = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [PIN_W-1:0]  pin_in,
   output logic [PIN_W-1:0]  pin_out,
   output logic [PIN_W-1:0]  pin_oe,
   output logic              irq
);

   if (PIN_W < 1 || PIN_W > DATA_W) begin : g_bad_width
      $error("PIN_W must lie between 1 and DATA_W");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must cover the register map");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   function automatic logic at(input logic [ADDR_W-1:0] a, input reg_ofs_e o);
      return a == ADDR_W'(o);
   endfunction

   logic              wr_en;
   logic              rd_en;
   wr_strobe_t        wr;
   logic [PIN_W-1:0]  wmask;
   logic [PIN_W-1:0]  dir_q;
   logic [PIN_W-1:0]  rise_q;
   logic [PIN_W-1:0]  fall_q;
   logic [PIN_W-1:0]  level;
   logic [PIN_W-1:0]  evt_q;
   logic [PIN_W-1:0]  rd_mux;

   assign wr_en = bus_sel && bus_we;
   assign rd_en = bus_sel && !bus_we;
   assign wmask = bus_wdata[PIN_W-1:0];

   assign wr.dir  = wr_en && at(bus_addr, OFS_DIR);
   assign wr.set  = wr_en && at(bus_addr, OFS_SET);
   assign wr.clr  = wr_en && at(bus_addr, OFS_CLR);
   assign wr.rise = wr_en && at(bus_addr, OFS_RISE);
   assign wr.fall = wr_en && at(bus_addr, OFS_FALL);
   assign wr.evt  = wr_en && at(bus_addr, OFS_EVT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         rise_q <= '0;
         fall_q <= '0;
      end else begin
         if (wr.dir)  dir_q  <= wmask;
         if (wr.rise) rise_q <= wmask;
         if (wr.fall) fall_q <= wmask;
      end
   end

   gpio_in_sync #(
      .WIDTH  (PIN_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_in   (pin_in),
      .sync_out (level)
   );

   gpio_edge_unit #(
      .WIDTH (PIN_W)
   ) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .level    (level),
      .rise_en  (rise_q),
      .fall_en  (fall_q),
      .clr_wr   (wr.evt),
      .clr_mask (wmask),
      .evt_q    (evt_q),
      .any_evt  (irq)
   );

   gpio_out_ctrl #(
      .WIDTH    (PIN_W),
      .INV_MASK (INV_MASK)
   ) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_wr (wr.set),
      .clr_wr (wr.clr),
      .mask   (wmask),
      .dir_q  (dir_q),
      .out_q  (pin_out),
      .oe     (pin_oe)
   );

   always_comb begin
      rd_mux = '0;
      if (at(bus_addr, OFS_LEVEL))     rd_mux = level;
      else if (at(bus_addr, OFS_DIR))  rd_mux = dir_q;
      else if (at(bus_addr, OFS_SET))  rd_mux = pin_out;
      else if (at(bus_addr, OFS_CLR))  rd_mux = pin_out;
      else if (at(bus_addr, OFS_RISE)) rd_mux = rise_q;
      else if (at(bus_addr, OFS_FALL)) rd_mux = fall_q;
      else if (at(bus_addr, OFS_EVT))  rd_mux = evt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bus_rdata <= '0;
      else if (rd_en) bus_rdata <= DATA_W'(rd_mux);
   end

endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk #(
   parameter int unsigned      PIN_W    = 32,
   parameter int unsigned      DATA_W   = 32,
   parameter int unsigned      ADDR_W   = 8,
   parameter logic [PIN_W-1:0] INV_MASK = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [PIN_W-1:0]  pin_out,
   input logic [PIN_W-1:0]  pin_oe,
   input logic              irq,
   input logic [PIN_W-1:0]  evt_q
);

   logic set_w, clr_w, dir_w, evt_w;
   logic [PIN_W-1:0] wm;

   assign set_w = bus_sel && bus_we && (bus_addr == ADDR_W'(8'h18));
   assign clr_w = bus_sel && bus_we && (bus_addr == ADDR_W'(8'h24));
   assign dir_w = bus_sel && bus_we && (bus_addr == ADDR_W'(8'h0C));
   assign evt_w = bus_sel && bus_we && (bus_addr == ADDR_W'(8'h48));
   assign wm    = bus_wdata[PIN_W-1:0];

   AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      set_w |=> ((pin_out & $past(wm)) == $past(wm))); // R2

   AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_w |=> ((pin_out & $past(wm)) == '0)); // R3

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_w || clr_w) |=> $stable(pin_out)); // R2

   AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !dir_w |=> $stable(pin_oe)); // R4

   AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_w |=> ((evt_q & $past(evt_q)) == $past(evt_q))); // R8

   AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(evt_w)); // R11

endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(
   .PIN_W    (PIN_W),
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .INV_MASK (INV_MASK)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .irq       (irq),
   .evt_q     (evt_q)
);

// File: tb/gpio_edge_bank_bench.sv
module gpio_edge_bank_bench;

   localparam logic [31:0] INV = 32'hF000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] ext_in = '0;
   logic [31:0] pin_in;
   logic [31:0] pin_out;
   logic [31:0] pin_oe;
   logic        irq;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext_in);

   gpio_edge_bank #(.INV_MASK(INV)) u_gpio_edge_bank (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R1 pin_out", pin_out, 32'h0);
      chk("R1 pin_oe", pin_oe, INV);
      chk("R1 irq", {31'h0, irq}, 32'h0);
      rd(8'h0C, d); chk("R1 dir", d, 32'h0);
      rd(8'h18, d); chk("R1 out latch", d, 32'h0);
      rd(8'h30, d); chk("R1 rise", d, 32'h0);
      rd(8'h3C, d); chk("R1 fall", d, 32'h0);
      rd(8'h48, d); chk("R1 evt", d, 32'h0);
   endtask

   task automatic t_outputs();
      logic [31:0] d;
      wr(8'h18, 32'hA5A5_0003); chk("R2 set", pin_out, 32'hA5A5_0003);
      wr(8'h18, 32'h0000_0100); chk("R2 set keeps others", pin_out, 32'hA5A5_0103);
      rd(8'h18, d);             chk("R2 readback", d, 32'hA5A5_0103);
      wr(8'h24, 32'h0000_0001); chk("R3 clear", pin_out, 32'hA5A5_0102);
      rd(8'h24, d);             chk("R3 readback", d, 32'hA5A5_0102);
      wr(8'h24, 32'hFFFF_FFFF); chk("R3 clear all", pin_out, 32'h0);
   endtask

   task automatic t_dir();
      logic [31:0] d;
      wr(8'h0C, 32'h0000_00FF); chk("R4 oe", pin_oe, 32'hF000_00FF);
      rd(8'h0C, d);             chk("R4 dir readback", d, 32'h0000_00FF);
      wr(8'h0C, 32'hF000_0000); chk("R4 inverted pins", pin_oe, 32'h0);
      wr(8'h0C, 32'h0);
   endtask

   task automatic t_level();
      logic [31:0] d;
      logic [31:0] exp;
      wr(8'h0C, 32'h0000_000F);
      wr(8'h18, 32'h0000_0005);
      ext_in = 32'h0123_4560;
      idle(4);
      exp = (pin_oe & pin_out) | (~pin_oe & ext_in);
      rd(8'h00, d); chk("R5 level mixed", d, exp);
      @(negedge clk);
      ext_in = 32'h0123_4570;
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 8'h00;
      @(negedge clk);
      d = bus_rdata; bus_sel = 1'b0;
      chk("R5 sync latency", d, exp);
      idle(3);
      rd(8'h00, d); chk("R5 level new", d, exp | 32'h0000_0010);
      wr(8'h24, 32'hFFFF_FFFF);
      wr(8'h0C, 32'h0);
      ext_in = 32'h0;
      idle(4);
      wr(8'h48, 32'hFFFF_FFFF);
   endtask

   task automatic t_edges();
      logic [31:0] d;
      wr(8'h30, 32'h0000_0008);
      wr(8'h3C, 32'h0000_0010);
      ext_in = 32'h0000_0018;
      idle(4);
      rd(8'h48, d); chk("R6 rise enabled only", d, 32'h0000_0008);
      chk("R11 irq set", {31'h0, irq}, 32'h1);
      ext_in = 32'h0;
      idle(4);
      rd(8'h48, d); chk("R7 fall enabled only", d, 32'h0000_0018);
      wr(8'h48, 32'h0000_0008);
      rd(8'h48, d); chk("R8 partial clear", d, 32'h0000_0010);
      wr(8'h48, 32'h0);
      rd(8'h48, d); chk("R8 zero write", d, 32'h0000_0010);
      wr(8'h48, 32'hFFFF_FFFF);
      rd(8'h48, d); chk("R8 clear all", d, 32'h0);
      chk("R11 irq low", {31'h0, irq}, 32'h0);
   endtask

   task automatic t_disable();
      logic [31:0] d;
      wr(8'h3C, 32'h0);
      wr(8'h30, 32'h0000_0040);
      ext_in = 32'h0000_0040;
      idle(4);
      wr(8'h30, 32'h0);
      rd(8'h48, d); chk("R9 pending kept", d, 32'h0000_0040);
      wr(8'h48, 32'h0000_0040);
      ext_in = 32'h0; idle(4);
      ext_in = 32'h0000_0040; idle(4);
      rd(8'h48, d); chk("R9 no new event", d, 32'h0);
      ext_in = 32'h0; idle(4);
   endtask

   task automatic t_collide();
      logic [31:0] d;
      wr(8'h30, 32'h0000_0020);
      wr(8'h3C, 32'h0000_0020);
      ext_in = 32'h0000_0020;
      idle(4);
      rd(8'h48, d); chk("R10 setup", d, 32'h0000_0020);
      @(negedge clk); ext_in = 32'h0;
      @(negedge clk);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 8'h48; bus_wdata = 32'h0000_0020;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
      rd(8'h48, d); chk("R10 edge beats clear", d, 32'h0000_0020);
      wr(8'h48, 32'h0000_0020);
      rd(8'h48, d); chk("R10 plain clear", d, 32'h0);
      wr(8'h30, 32'h0);
      wr(8'h3C, 32'h0);
   endtask

   task automatic t_unmapped();
      logic [31:0] d;
      wr(8'h0C, 32'h1234_5678);
      rd(8'h04, d); chk("R12 unmapped 0x04", d, 32'h0);
      rd(8'h50, d); chk("R12 unmapped 0x50", d, 32'h0);
      wr(8'h0C, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_outputs();
      t_dir();
      t_level();
      t_edges();
      t_disable();
      t_collide();
      t_unmapped();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule